// File: doc/BRIEF.md
# Serial NOR Flash Configuration and Block-Protection Controller

This block holds the configuration and block-protection state of a serial NOR flash. It does not decode commands. It takes a decoded register write, made of a status byte, a configuration byte and a strobe. It also takes three reset events (power-on, hardware and command) and a pulse that marks the first program or erase of the main array. Three configuration bits are one-time programmable:

- the protection anchor, bit 5;
- the protect-bit volatility, bit 3;
- the parameter-region location, bit 2.

Each of these bits can only be raised. An attempt to lower one sets a sticky program-error flag in status bit 6.

The block has a combinational address checker. It reports whether a 24-bit array address lies inside the protected range chosen by the three block-protect bits, which sit in status bits [4:2]. It also reports whether the address lies in the 128 KB small-sector parameter region. A command decoder uses these flags to refuse program or erase to protected space and to pick the sector size.

Top module: `flash_protect_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to its unprogrammed state, with `status_q` = 0x00 and `config_q` = 0x00. Register writes take effect on the next clock edge.
- R2: A write sets each OTP bit that is 1 in `wr_config`. OTP bits that are already 1 stay 1. If the write carries 0 for an OTP bit that is currently 1, `status_q[6]` becomes 1.
- R3: With `config_q[3]` = 0, the block-protect bits `status_q[4:2]` keep their value through power-on, hardware and command reset events.
- R4: With `config_q[3]` = 1, any of the three reset events loads `status_q[4:2]` with 111.
- R5: A write loads `status_q[4:2]` from `wr_status[4:2]`. A reset event in the same cycle takes precedence, and the whole write is dropped.
- R6: With `config_q[5]` = 0, the protected range ends at the highest address. Its size is none for 000, 1/64 of the array for 001, and doubles with each higher code up to 1/2 for 110. Code 111 protects the whole array.
- R7: With `config_q[5]` = 1, the protected range has the same sizes as in R6 but starts at address 0.
- R8: `addr_in_param` marks the top 128 KB of the array when `config_q[2]` = 1 and the bottom 128 KB when it is 0. This holds for either value of `config_q[5]`.
- R9: While `uniform_mode` is 1, `addr_in_param` is 0 for every address.
- R10: Configuration bit 4 reads 0 and ignores writes. Configuration bits 7, 6, 1 and 0 read 0, and so do status bits 7, 5, 1 and 0.
- R11: Once `array_mod` has pulsed, a write that would change any OTP bit leaves all OTP bits unchanged and sets `status_q[6]`. A write that changes no OTP bit sets no error. Only `rst_n` clears this lock.
- R12: `status_q[6]` is cleared only by `clr_status` or a power-on reset event, and hardware or command reset leave it set. A new error in the same cycle as `clr_status` wins, and the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low initialisation to the unprogrammed state |
| por_evt | input | 1 | Power-on reset event, one cycle |
| hw_rst_evt | input | 1 | Hardware reset event, one cycle |
| cmd_rst_evt | input | 1 | Command reset event, one cycle |
| wr_en | input | 1 | Register write strobe |
| wr_status | input | 8 | Status byte to write; bits [4:2] are block-protect |
| wr_config | input | 8 | Configuration byte to write |
| clr_status | input | 1 | Clears the program-error flag |
| array_mod | input | 1 | Pulse marking an array program or erase |
| uniform_mode | input | 1 | Array organised as uniform 256 KB sectors |
| chk_addr | input | 24 | Address to classify |
| status_q | output | 8 | Status register read value |
| config_q | output | 8 | Configuration register read value |
| addr_protected | output | 1 | `chk_addr` lies in the protected range |
| addr_in_param | output | 1 | `chk_addr` lies in the parameter region |

## Verification
A wrong OTP, volatility or lock state shows on `config_q` and `status_q` in the cycle after the write or reset event that exposed it. The bench reads both registers at that point after every such event. A wrong anchor or protect code shows at once on `addr_protected` and `addr_in_param`, with no clock involved. The bench therefore sweeps every protect code, anchor, parameter location and sector mode against addresses that sit on and beside every power-of-two region boundary. It compares each result with arithmetic bounds.

// File: rtl/fpc_pkg.sv
// Package: shared widths and the OTP bit bundle for the flash protection block.
// Assumes a byte-wide register interface and three block-protect bits.
package fpc_pkg;
    localparam int BP_W    = 3;
    localparam int OTP_N   = 3;

    // One-time-programmable configuration bits, stored together.
    typedef struct packed {
        logic anchor_low;   // protected range starts at address 0
        logic bp_volatile;  // block-protect bits reload to all-ones on reset
        logic param_high;   // parameter region at the top of the array
    } otp_t;
endpackage

// File: rtl/fpc_otp_regs.sv
// Module: OTP configuration bits, array-touched lock and program-error flag.
// Assumes reset events arrive as one-cycle pulses; any of them drops a write.
module fpc_otp_regs
    import fpc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_rst,
    input  logic por_evt,
    input  logic wr_en,
    input  otp_t wr_otp,
    input  logic array_mod,
    input  logic clr_err,
    output otp_t otp_q,
    output logic perr_q
);
    logic touched_q;
    logic err_set;
    logic wr_go;
    logic seen_clk;

    // Decide whether this cycle's write is a rejected OTP change.
    always_comb begin
        wr_go   = wr_en && !any_rst;
        err_set = 1'b0;
        if (wr_go) begin
            if (touched_q) err_set = (wr_otp != otp_q);
            else           err_set = |(otp_q & ~wr_otp);
        end
    end

    // OTP bits: raised by writes until the array has been modified.
    always_ff @(posedge clk) begin
        if (!rst_n)                       otp_q <= '0;
        else if (wr_go && !touched_q)     otp_q <= otp_q | wr_otp;
    end

    // Sticky record of the first array program or erase.
    always_ff @(posedge clk) begin
        if (!rst_n)         touched_q <= 1'b0;
        else if (array_mod) touched_q <= 1'b1;
    end

    // Program-error flag: a new error wins over clearing.
    always_ff @(posedge clk) begin
        if (!rst_n)                    perr_q <= 1'b0;
        else if (err_set)              perr_q <= 1'b1;
        else if (clr_err || por_evt)   perr_q <= 1'b0;
    end

    // Marks that $past now refers to a post-reset cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_clk <= 1'b0;
        else        seen_clk <= 1'b1;
    end

    AST_OTP_NEVER_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        seen_clk |-> (($past(otp_q) & ~otp_q) == '0)); // R2
    AST_CLEAR_FLAGS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !any_rst && |(otp_q & ~wr_otp)) |=> perr_q); // R2
    AST_LOCK_FREEZES_OTP: assert property (@(posedge clk) disable iff (!rst_n)
        touched_q |=> $stable(otp_q)); // R11
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (perr_q && !clr_err && !por_evt) |=> perr_q); // R12
endmodule

// File: rtl/fpc_bp_reg.sv
// Module: block-protect bits with optional volatile reload on reset events.
// Assumes any_rst is the OR of the three reset event pulses.
module fpc_bp_reg
    import fpc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            any_rst,
    input  logic            bp_volatile,
    input  logic            wr_en,
    input  logic [BP_W-1:0] wr_bp,
    output logic [BP_W-1:0] bp_q
);
    // Reset events reload or hold; otherwise a write loads the code.
    always_ff @(posedge clk) begin
        if (!rst_n)          bp_q <= '0;
        else if (any_rst) begin
            if (bp_volatile) bp_q <= '1;
        end
        else if (wr_en)      bp_q <= wr_bp;
    end

    AST_BP_VOLATILE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (any_rst && bp_volatile) |=> (bp_q == '1)); // R4
    AST_BP_NV_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (any_rst && !bp_volatile) |=> $stable(bp_q)); // R3
    AST_BP_WRITE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !any_rst) |=> (bp_q == $past(wr_bp))); // R5
endmodule

// File: rtl/fpc_region_match.sv
// Module: tests whether an address lies in an aligned power-of-two region
// anchored at either end of the address space. span_lg = ADDR_W covers all.
module fpc_region_match #(
    parameter int ADDR_W = 24,
    localparam int SPAN_W = $clog2(ADDR_W + 1)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SPAN_W-1:0] span_lg,
    input  logic              at_top,
    input  logic              enable,
    output logic              hit
);
    logic [ADDR_W-1:0] hi_mask;

    // Mask of the address bits above the region size.
    always_comb begin
        for (int i = 0; i < ADDR_W; i++)
            hi_mask[i] = (i >= int'(span_lg));
    end

    // High bits all ones at the top anchor, all zeros at the bottom.
    always_comb begin
        if (!enable)     hit = 1'b0;
        else if (at_top) hit = ((addr & hi_mask) == hi_mask);
        else             hit = ((addr & hi_mask) == '0);
    end
endmodule

// File: rtl/flash_protect_ctrl.sv
// Module: top of the flash configuration and block-protection controller.
// Assumes decoded register writes and one-cycle reset event pulses.
module flash_protect_ctrl
    import fpc_pkg::*;
#(
    parameter int ADDR_W       = 24,
    parameter int SMALL_SEC_LG = 12,
    parameter int PARAM_CNT_LG = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_evt,
    input  logic              hw_rst_evt,
    input  logic              cmd_rst_evt,
    input  logic              wr_en,
    input  logic [7:0]        wr_status,
    input  logic [7:0]        wr_config,
    input  logic              clr_status,
    input  logic              array_mod,
    input  logic              uniform_mode,
    input  logic [ADDR_W-1:0] chk_addr,
    output logic [7:0]        status_q,
    output logic [7:0]        config_q,
    output logic              addr_protected,
    output logic              addr_in_param
);
    localparam int SPAN_W     = $clog2(ADDR_W + 1);
    localparam int MIN_SPAN   = ADDR_W - (2**BP_W - 1);
    localparam int PARAM_SPAN = SMALL_SEC_LG + PARAM_CNT_LG;

    logic            any_rst;
    otp_t            wr_otp;
    otp_t            otp_q;
    logic            perr_q;
    logic [BP_W-1:0] bp_q;
    logic [SPAN_W-1:0] prot_span;
    logic            unused_wr_bits;

    // Merge reset events and split out the writable fields.
    always_comb begin
        any_rst = por_evt | hw_rst_evt | cmd_rst_evt;
        wr_otp  = '{anchor_low: wr_config[5], bp_volatile: wr_config[3],
                    param_high: wr_config[2]};
        prot_span = SPAN_W'(MIN_SPAN) + SPAN_W'(bp_q);
    end

    assign unused_wr_bits = ^{wr_status[7:5], wr_status[1:0],
                              wr_config[7:6], wr_config[4], wr_config[1:0]};

    fpc_otp_regs u_otp (
        .clk       (clk),
        .rst_n     (rst_n),
        .any_rst   (any_rst),
        .por_evt   (por_evt),
        .wr_en     (wr_en),
        .wr_otp    (wr_otp),
        .array_mod (array_mod),
        .clr_err   (clr_status),
        .otp_q     (otp_q),
        .perr_q    (perr_q)
    );

    fpc_bp_reg u_bp (
        .clk         (clk),
        .rst_n       (rst_n),
        .any_rst     (any_rst),
        .bp_volatile (otp_q.bp_volatile),
        .wr_en       (wr_en),
        .wr_bp       (wr_status[4:2]),
        .bp_q        (bp_q)
    );

    fpc_region_match #(.ADDR_W(ADDR_W)) u_prot (
        .addr    (chk_addr),
        .span_lg (prot_span),
        .at_top  (!otp_q.anchor_low),
        .enable  (bp_q != '0),
        .hit     (addr_protected)
    );

    fpc_region_match #(.ADDR_W(ADDR_W)) u_param (
        .addr    (chk_addr),
        .span_lg (SPAN_W'(PARAM_SPAN)),
        .at_top  (otp_q.param_high),
        .enable  (!uniform_mode),
        .hit     (addr_in_param)
    );

    // Assemble the read values; unlisted bits read zero.
    always_comb begin
        status_q = {1'b0, perr_q, 1'b0, bp_q, 2'b00};
        config_q = {2'b00, otp_q.anchor_low, 1'b0, otp_q.bp_volatile,
                    otp_q.param_high, 2'b00};
    end

    AST_UNIFORM_NO_PARAM: assert property (@(posedge clk) disable iff (!rst_n)
        uniform_mode |-> !addr_in_param); // R9
    AST_FULL_CODE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (bp_q == '1) |-> addr_protected); // R6
endmodule

// File: tb/flash_protect_ctrl_bench.sv
module flash_protect_ctrl_bench;
    localparam int AW = 24;

    logic clk = 1'b0;
    logic rst_n, por_evt, hw_rst_evt, cmd_rst_evt, wr_en, clr_status;
    logic array_mod, uniform_mode;
    logic [7:0] wr_status, wr_config, status_q, config_q;
    logic [AW-1:0] chk_addr;
    logic addr_protected, addr_in_param;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    flash_protect_ctrl u_flash_protect_ctrl (
        .clk(clk), .rst_n(rst_n), .por_evt(por_evt), .hw_rst_evt(hw_rst_evt),
        .cmd_rst_evt(cmd_rst_evt), .wr_en(wr_en), .wr_status(wr_status),
        .wr_config(wr_config), .clr_status(clr_status), .array_mod(array_mod),
        .uniform_mode(uniform_mode), .chk_addr(chk_addr), .status_q(status_q),
        .config_q(config_q), .addr_protected(addr_protected),
        .addr_in_param(addr_in_param)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic init();
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic wr(input logic [7:0] s, input logic [7:0] c);
        wr_en = 1'b1; wr_status = s; wr_config = c;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic pulse_rst(input int which);
        por_evt = (which == 0); hw_rst_evt = (which == 1); cmd_rst_evt = (which == 2);
        tick();
        por_evt = 1'b0; hw_rst_evt = 1'b0; cmd_rst_evt = 1'b0;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; por_evt = 0; hw_rst_evt = 0; cmd_rst_evt = 0; wr_en = 0;
        clr_status = 0; array_mod = 0; uniform_mode = 0;
        wr_status = 0; wr_config = 0; chk_addr = '0;
        @(negedge clk);
        init();
        // R1 unprogrammed state
        chk("R1 status", status_q, 8'h00);
        chk("R1 config", config_q, 8'h00);
        chk("R1 no protection", addr_protected, 0);

        // R10 reserved and unused bits
        wr(8'hFF, 8'hFF);
        chk("R10 config read", config_q, 8'h2C);
        chk("R10 status read", status_q, 8'h1C);

        // R2 clearing attempt: bits held, error set
        wr(8'h00, 8'h00);
        chk("R2 otp held", config_q, 8'h2C);
        chk("R2 error set", status_q, 8'h40);

        // R4 and R12: hw/cmd reset keep error, reload BP with volatile set
        pulse_rst(1);
        chk("R4 hw reload / R12 keep", status_q, 8'h5C);
        wr(8'h00, 8'h2C);
        pulse_rst(2);
        chk("R4 cmd reload / R12 keep", status_q, 8'h5C);
        clr_status = 1'b1; tick(); clr_status = 1'b0;
        chk("R12 clr_status", status_q, 8'h1C);
        wr(8'h00, 8'h00);
        pulse_rst(0);
        chk("R4 por reload / R12 por clears", status_q, 8'h1C);
        // R12 set wins over clear
        clr_status = 1'b1; wr(8'h00, 8'h00); clr_status = 1'b0;
        chk("R12 set wins", status_q, 8'h40);

        // R3 non-volatile BP keeps value
        init();
        wr(8'h14, 8'h00);
        chk("R5 bp write", status_q, 8'h14);
        for (int w = 0; w < 3; w++) begin
            pulse_rst(w);
            chk("R3 bp kept", status_q, 8'h14);
        end
        // R5 reset event drops same-cycle write
        hw_rst_evt = 1'b1; wr(8'h08, 8'h20); hw_rst_evt = 1'b0;
        chk("R5 write dropped status", status_q, 8'h14);
        chk("R5 write dropped config", config_q, 8'h00);

        // R11 lock after array modification
        init();
        array_mod = 1'b1; tick(); array_mod = 1'b0;
        wr(8'h00, 8'h04);
        chk("R11 raise rejected", config_q, 8'h00);
        chk("R11 error set", status_q, 8'h40);
        clr_status = 1'b1; tick(); clr_status = 1'b0;
        pulse_rst(1);
        wr(8'h00, 8'h20);
        chk("R11 lock survives reset", config_q, 8'h00);
        clr_status = 1'b1; tick(); clr_status = 1'b0;
        wr(8'h00, 8'h00);
        chk("R11 no-change write no error", status_q, 8'h00);

        // R6 R7 R8 R9 sweep
        for (int tb = 0; tb < 2; tb++) begin
            for (int pr = 0; pr < 2; pr++) begin
                init();
                wr(8'h00, 8'((tb << 5) | (pr << 2)));
                for (int bp = 0; bp < 8; bp++) begin
                    wr(8'(bp << 2), 8'((tb << 5) | (pr << 2)));
                    for (int um = 0; um < 2; um++) begin
                        uniform_mode = um[0];
                        for (int k = 12; k <= 24; k++) begin
                            for (int v = 0; v < 6; v++) begin
                                longint a, size, psz;
                                logic ep, epar;
                                case (v)
                                    0: a = (64'd1 << k) - 1;
                                    1: a = (64'd1 << k);
                                    2: a = (64'd1 << 24) - (64'd1 << k);
                                    3: a = (64'd1 << 24) - (64'd1 << k) - 1;
                                    4: a = 0;
                                    default: a = (64'd1 << 24) - 1;
                                endcase
                                a = a & 64'hFFFFFF;
                                size = (bp == 0) ? 0 : (64'd1 << (17 + bp));
                                ep = (tb == 0) ? (a >= (64'd1 << 24) - size) && size != 0
                                               : (a < size);
                                psz = 64'd1 << 17;
                                epar = (um == 1) ? 1'b0 :
                                       (pr == 1) ? (a >= (64'd1 << 24) - psz) : (a < psz);
                                chk_addr = a[AW-1:0];
                                #1;
                                chk(tb == 0 ? "R6 protect top" : "R7 protect bottom",
                                    addr_protected, ep);
                                chk(um == 1 ? "R9 uniform param" : "R8 param region",
                                    addr_in_param, epar);
                            end
                        end
                    end
                    uniform_mode = 1'b0;
                end
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule